// File: doc/BRIEF.md
# Video Memory Block Mover

This block copies 16-bit words inside video memory without CPU involvement. It has two jobs. The first is a block copy from one video memory address range to another. The host sets a source, a destination, a word count and a stepping direction for each pointer, and the copy begins when the upper byte of the count register is written. The second is a fill of a local 256-word sprite attribute table from a run of video memory. A write to the table-source register arms this fill. The fill then runs at the next vertical-blank strobe, and it repeats on every later strobe only when auto-repeat is enabled.

Both jobs share one video memory port that uses a request/grant handshake. The host's own memory traffic always wins: the mover drops its request whenever a host access is pending. When a job finishes, the block sets a done flag for that job and raises an interrupt if that job's enable bit is set. A status-read strobe clears both flags. The sprite renderer reads the table through a synchronous read port.

Top module: `vram_dma_engine`

## Requirements
- R1: After reset both done flags, `irq` and `vram_req` are low.
- R2: Register writes are byte-wide. `reg_hi`=1 selects bits 15:8 and `reg_hi`=0 selects bits 7:0. The indices are 0x0F control, 0x10 source, 0x11 destination, 0x12 count and 0x13 table source. A block copy starts only on an upper-byte write to 0x12. Writing the lower byte alone causes no memory traffic.
- R3: A block copy moves count+1 words. It reads each word from the source pointer and then writes it to the destination pointer, one word at a time and in pointer order.
- R4: Control bit 2 set makes the source pointer step down by one per word, and clear makes it step up. Control bit 3 does the same for the destination pointer. Both pointers wrap modulo 65536.
- R5: When a block copy ends, `flag_blk` goes high. `irq` is high for it only if control bit 1 is set.
- R6: Any byte write to index 0x13 arms one table fill. At the next `vblank` pulse the block reads 256 consecutive words upward from that address, wrapping modulo 65536, into table entries 0 to 255. A fill never writes video memory.
- R7: With control bit 4 clear, a `vblank` pulse that comes without a fresh arm starts no fill. With control bit 4 set, every `vblank` pulse starts a fill.
- R8: When a table fill ends, `flag_tbl` goes high. `irq` is high for it only if control bit 0 is set.
- R9: `vram_req` is never high while `host_pending` is high. A request that is not granted keeps the same address and direction until it is granted.
- R10: A one-cycle `stat_rd` pulse clears both done flags, and with them the interrupt.
- R11: The table read port returns the entry at `tbl_raddr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register byte write strobe |
| reg_hi | input | 1 | 1 = upper byte, 0 = lower byte |
| reg_addr | input | 5 | Register index |
| reg_wdata | input | 8 | Byte to write |
| stat_rd | input | 1 | Status read, clears both done flags |
| vblank | input | 1 | Vertical-blank strobe, one cycle |
| host_pending | input | 1 | Host video memory access pending |
| vram_gnt | input | 1 | Grant for the current request |
| vram_rdata | input | 16 | Read data, valid the cycle after a granted read |
| tbl_raddr | input | 8 | Table read address |
| vram_req | output | 1 | Memory cycle request |
| vram_we | output | 1 | 1 = write, 0 = read |
| vram_addr | output | 16 | Memory word address |
| vram_wdata | output | 16 | Write data |
| tbl_rdata | output | 16 | Table read data |
| flag_blk | output | 1 | Block copy done flag |
| flag_tbl | output | 1 | Table fill done flag |
| irq | output | 1 | Interrupt, done flags gated by enables |

## Verification
Block copies are run with all up-counting pointers, with both pointers counting down across the 0x0000/0xFFFF boundary, and with mixed directions. These runs separate the direction bit of each pointer from the other and show that wrapping works. One descending run uses overlapping ranges, which exposes any reordering of read and write within a word. A lone lower-byte count write and a plain `vblank` without arming must produce no traffic at all. Repeat-mode fills with and without the interrupt enable separate the one-shot arm from the repeat bit. Host-pending and grant stalls are random throughout, and every bus cycle is compared against the bench model's expected pointer and data.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int IDX_W = 5;
  localparam logic [IDX_W-1:0] IDX_CTRL = 5'h0F;
  localparam logic [IDX_W-1:0] IDX_SRC  = 5'h10;
  localparam logic [IDX_W-1:0] IDX_LEN  = 5'h12;
  localparam logic [IDX_W-1:0] IDX_TSRC = 5'h13;
  localparam int CTRL_W   = 5;
  localparam int CB_TBLIE = 0;
  localparam int CB_BLKIE = 1;
  localparam int CB_SDEC  = 2;
  localparam int CB_DDEC  = 3;
  localparam int CB_RPT   = 4;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_LAND, ST_WRITE} seq_st_e;
endpackage

// File: rtl/vdma_regs.sv
module vdma_regs
  import vdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_hi,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [7:0]        reg_wdata,
  input  logic              vblank,
  input  logic              stat_rd,
  input  logic              ack_blk,
  input  logic              ack_tbl,
  input  logic              done_blk,
  input  logic              done_tbl,
  output logic [AW-1:0]     src_q,
  output logic [AW-1:0]     dst_q,
  output logic [AW-1:0]     len_q,
  output logic [AW-1:0]     tsrc_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              blk_pend,
  output logic              tbl_pend,
  output logic              flag_blk,
  output logic              flag_tbl,
  output logic              irq
);
  localparam int NWREG = 4;

  // Word registers 0x10..0x13, written one byte at a time
  generate
    for (genvar k = 0; k < NWREG; k++) begin : g_wreg
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(IDX_SRC + k);
      logic [AW-1:0] q;
      logic hit;
      assign hit = reg_we && (reg_addr == MY_IDX);
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (hit) begin
          if (reg_hi) q[AW-1:8] <= (AW-8)'(reg_wdata);
          else        q[7:0]    <= reg_wdata;
        end
      end
    end
  endgenerate

  assign src_q  = g_wreg[0].q;
  assign dst_q  = g_wreg[1].q;
  assign len_q  = g_wreg[2].q;
  assign tsrc_q = g_wreg[3].q;

  logic len_go, tsrc_wr, tbl_arm;
  assign len_go  = reg_we && reg_hi && (reg_addr == IDX_LEN);
  assign tsrc_wr = reg_we && (reg_addr == IDX_TSRC);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      blk_pend <= 1'b0;
      tbl_pend <= 1'b0;
      tbl_arm  <= 1'b0;
      flag_blk <= 1'b0;
      flag_tbl <= 1'b0;
    end else begin
      if (reg_we && !reg_hi && reg_addr == IDX_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
      if (len_go)       blk_pend <= 1'b1;
      else if (ack_blk) blk_pend <= 1'b0;
      if (tsrc_wr)      tbl_arm <= 1'b1;
      else if (vblank)  tbl_arm <= 1'b0;
      if (vblank && (tbl_arm || ctrl_q[CB_RPT])) tbl_pend <= 1'b1;
      else if (ack_tbl) tbl_pend <= 1'b0;
      if (done_blk)     flag_blk <= 1'b1;
      else if (stat_rd) flag_blk <= 1'b0;
      if (done_tbl)     flag_tbl <= 1'b1;
      else if (stat_rd) flag_tbl <= 1'b0;
    end
  end

  assign irq = (flag_blk && ctrl_q[CB_BLKIE]) || (flag_tbl && ctrl_q[CB_TBLIE]);

  // R2: upper count byte arms a block copy
  p_len_arm_r2: assert property (@(posedge clk) disable iff (rst) len_go |=> blk_pend);
  // R5: sequencer completion reaches the flag
  p_blk_flag_r5: assert property (@(posedge clk) disable iff (rst) done_blk |=> flag_blk);
  // R8
  p_tbl_flag_r8: assert property (@(posedge clk) disable iff (rst) done_tbl |=> flag_tbl);
  // R10
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !done_blk && !done_tbl) |=> (!flag_blk && !flag_tbl));
  // R7: unarmed strobe without repeat leaves nothing pending
  p_noarm_r7: assert property (@(posedge clk) disable iff (rst)
    (vblank && !tbl_arm && !tsrc_wr && !ctrl_q[CB_RPT] && !tbl_pend) |=> !tbl_pend);
endmodule

// File: rtl/vdma_seq.sv
module vdma_seq
  import vdma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int TAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           host_pending,
  input  logic           vram_gnt,
  input  logic [DW-1:0]  vram_rdata,
  input  logic [AW-1:0]  src_q,
  input  logic [AW-1:0]  dst_q,
  input  logic [AW-1:0]  len_q,
  input  logic [AW-1:0]  tsrc_q,
  input  logic           sdec_cfg,
  input  logic           ddec_cfg,
  input  logic           blk_pend,
  input  logic           tbl_pend,
  output logic           ack_blk,
  output logic           ack_tbl,
  output logic           done_blk,
  output logic           done_tbl,
  output logic           vram_req,
  output logic           vram_we,
  output logic [AW-1:0]  vram_addr,
  output logic [DW-1:0]  vram_wdata,
  output logic           tbl_we,
  output logic [TAW-1:0] tbl_waddr,
  output logic [DW-1:0]  tbl_wdata
);
  localparam logic [AW-1:0] TBL_LAST = AW'((2 ** TAW) - 1);

  seq_st_e        st_q;
  logic           is_tbl_q, sdec_q, ddec_q;
  logic [AW-1:0]  sp_q, dp_q, cnt_q;
  logic [TAW-1:0] tix_q;
  logic [DW-1:0]  data_q;
  logic           xfer, last;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic dec);
    return dec ? a - 1'b1 : a + 1'b1;
  endfunction

  assign xfer     = vram_req && vram_gnt;
  assign last     = (cnt_q == '0);
  assign ack_tbl  = (st_q == ST_IDLE) && tbl_pend;
  assign ack_blk  = (st_q == ST_IDLE) && !tbl_pend && blk_pend;
  assign done_tbl = (st_q == ST_LAND) && is_tbl_q && last;
  assign done_blk = (st_q == ST_WRITE) && xfer && last;

  assign vram_req   = ((st_q == ST_READ) || (st_q == ST_WRITE)) && !host_pending;
  assign vram_we    = (st_q == ST_WRITE);
  assign vram_addr  = (st_q == ST_WRITE) ? dp_q : sp_q;
  assign vram_wdata = data_q;
  assign tbl_we     = (st_q == ST_LAND) && is_tbl_q;
  assign tbl_waddr  = tix_q;
  assign tbl_wdata  = vram_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      is_tbl_q <= 1'b0;
      sdec_q   <= 1'b0;
      ddec_q   <= 1'b0;
      sp_q     <= '0;
      dp_q     <= '0;
      cnt_q    <= '0;
      tix_q    <= '0;
      data_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (ack_tbl) begin
            is_tbl_q <= 1'b1;
            sp_q     <= tsrc_q;
            sdec_q   <= 1'b0;
            cnt_q    <= TBL_LAST;
            tix_q    <= '0;
            st_q     <= ST_READ;
          end else if (ack_blk) begin
            is_tbl_q <= 1'b0;
            sp_q     <= src_q;
            dp_q     <= dst_q;
            cnt_q    <= len_q;
            sdec_q   <= sdec_cfg;
            ddec_q   <= ddec_cfg;
            st_q     <= ST_READ;
          end
        end
        ST_READ: begin
          if (xfer) begin
            sp_q <= step(sp_q, sdec_q);
            st_q <= ST_LAND;
          end
        end
        ST_LAND: begin
          data_q <= vram_rdata;
          if (!is_tbl_q) st_q <= ST_WRITE;
          else if (last) st_q <= ST_IDLE;
          else begin
            cnt_q <= cnt_q - 1'b1;
            tix_q <= tix_q + 1'b1;
            st_q  <= ST_READ;
          end
        end
        ST_WRITE: begin
          if (xfer) begin
            dp_q <= step(dp_q, ddec_q);
            if (last) st_q <= ST_IDLE;
            else begin
              cnt_q <= cnt_q - 1'b1;
              st_q  <= ST_READ;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9: an ungranted request holds its cycle
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (vram_req && !vram_gnt) |=> ($stable(vram_addr) && $stable(vram_we)));
  // R6: a table fill never writes video memory
  p_tbl_nowr_r6: assert property (@(posedge clk) disable iff (rst)
    (vram_req && vram_we) |-> !is_tbl_q);
  // R3: a granted read is followed by data landing
  p_land_r3: assert property (@(posedge clk) disable iff (rst)
    (xfer && !vram_we) |=> (st_q == ST_LAND));
endmodule

// File: rtl/vdma_tbl_ram.sv
module vdma_tbl_ram #(
  parameter int DW  = 16,
  parameter int TAW = 8
) (
  input  logic           clk,
  input  logic           we,
  input  logic [TAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [TAW-1:0] raddr,
  output logic [DW-1:0]  rdata
);
  localparam int DEPTH = 2 ** TAW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine
  import vdma_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int TAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic           reg_hi,
  input  logic [4:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  input  logic           stat_rd,
  input  logic           vblank,
  input  logic           host_pending,
  input  logic           vram_gnt,
  input  logic [DW-1:0]  vram_rdata,
  input  logic [TAW-1:0] tbl_raddr,
  output logic           vram_req,
  output logic           vram_we,
  output logic [AW-1:0]  vram_addr,
  output logic [DW-1:0]  vram_wdata,
  output logic [DW-1:0]  tbl_rdata,
  output logic           flag_blk,
  output logic           flag_tbl,
  output logic           irq
);
  logic [AW-1:0]     src_q, dst_q, len_q, tsrc_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              blk_pend, tbl_pend, ack_blk, ack_tbl, done_blk, done_tbl;
  logic              tbl_we;
  logic [TAW-1:0]    tbl_waddr;
  logic [DW-1:0]     tbl_wdata;

  vdma_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_hi(reg_hi), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .vblank(vblank), .stat_rd(stat_rd),
    .ack_blk(ack_blk), .ack_tbl(ack_tbl), .done_blk(done_blk), .done_tbl(done_tbl),
    .src_q(src_q), .dst_q(dst_q), .len_q(len_q), .tsrc_q(tsrc_q), .ctrl_q(ctrl_q),
    .blk_pend(blk_pend), .tbl_pend(tbl_pend), .flag_blk(flag_blk), .flag_tbl(flag_tbl),
    .irq(irq)
  );

  vdma_seq #(.AW(AW), .DW(DW), .TAW(TAW)) u_seq (
    .clk(clk), .rst(rst), .host_pending(host_pending), .vram_gnt(vram_gnt),
    .vram_rdata(vram_rdata), .src_q(src_q), .dst_q(dst_q), .len_q(len_q), .tsrc_q(tsrc_q),
    .sdec_cfg(ctrl_q[CB_SDEC]), .ddec_cfg(ctrl_q[CB_DDEC]),
    .blk_pend(blk_pend), .tbl_pend(tbl_pend), .ack_blk(ack_blk), .ack_tbl(ack_tbl),
    .done_blk(done_blk), .done_tbl(done_tbl), .vram_req(vram_req), .vram_we(vram_we),
    .vram_addr(vram_addr), .vram_wdata(vram_wdata), .tbl_we(tbl_we),
    .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata)
  );

  vdma_tbl_ram #(.DW(DW), .TAW(TAW)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .raddr(tbl_raddr), .rdata(tbl_rdata)
  );

  // R9: host traffic always wins the port
  p_yield_r9: assert property (@(posedge clk) disable iff (rst) host_pending |-> !vram_req);
  // R1: quiet right after reset
  p_reset_r1: assert property (@(posedge clk) $fell(rst) |-> (!flag_blk && !flag_tbl && !vram_req));
endmodule

// File: tb/tb_vram_dma_engine.sv
module tb_vram_dma_engine;
  localparam int CLK_NS = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 0, reg_hi = 0, stat_rd = 0, vblank = 0, host_pending = 0, vram_gnt = 0;
  logic [4:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [15:0] vram_rdata = '0;
  logic [7:0] tbl_raddr = '0;
  logic vram_req, vram_we, flag_blk, flag_tbl, irq;
  logic [15:0] vram_addr, vram_wdata, tbl_rdata;

  vram_dma_engine dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_hi(reg_hi), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .stat_rd(stat_rd), .vblank(vblank), .host_pending(host_pending),
    .vram_gnt(vram_gnt), .vram_rdata(vram_rdata), .tbl_raddr(tbl_raddr),
    .vram_req(vram_req), .vram_we(vram_we), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
    .tbl_rdata(tbl_rdata), .flag_blk(flag_blk), .flag_tbl(flag_tbl), .irq(irq)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int nchk = 0, nbad = 0, cyc = 0;
  logic [15:0] shadow [int];

  // model state
  bit blk_on = 0, tbl_on = 0, m_sdec = 0, m_ddec = 0;
  logic [15:0] m_src, m_dst, m_data;
  int rdn = 0, wrn = 0;

  // captured bus cycle
  bit c_valid = 0, c_we = 0;
  logic [15:0] c_addr, c_wdata;

  function automatic logic [15:0] vread(input logic [15:0] a);
    if (shadow.exists(int'(a))) return shadow[int'(a)];
    return (a * 16'h9E37) ^ 16'h5A3C;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural memory slave and per-cycle bus comparison
  always @(negedge clk) begin
    if (c_valid) begin
      if (!c_we) begin
        vram_rdata = vread(c_addr);
        if (blk_on) begin
          chk(c_addr == m_src, "R4 read addr", c_addr, m_src);
          m_data = vread(c_addr);
          m_src = m_sdec ? m_src - 16'd1 : m_src + 16'd1;
          rdn++;
        end else if (tbl_on) begin
          chk(c_addr == m_src, "R6 table read addr", c_addr, m_src);
          m_src = m_src + 16'd1;
          rdn++;
        end else chk(0, "R7 unexpected read", c_addr, 0);
      end else begin
        if (blk_on) begin
          chk(c_addr == m_dst, "R4 write addr", c_addr, m_dst);
          chk(c_wdata == m_data, "R3 write data", c_wdata, m_data);
          m_dst = m_ddec ? m_dst - 16'd1 : m_dst + 16'd1;
          wrn++;
        end else chk(0, "R2 unexpected write", c_addr, 0);
        shadow[int'(c_addr)] = c_wdata;
      end
    end
    c_valid = 0;
    host_pending = rst ? 1'b0 : ($urandom % 4 == 0);
    vram_gnt = !host_pending && ($urandom % 10 < 7);
    #1;
    if (!rst) begin
      chk(!(vram_req && host_pending), "R9 request during host access", vram_req, 0);
      if (vram_req && vram_gnt) begin
        c_valid = 1; c_we = vram_we; c_addr = vram_addr; c_wdata = vram_wdata;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      nbad++;
      nchk++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  task automatic wbyte(input logic [4:0] idx, input bit hi, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_hi = hi; reg_addr = idx; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic wword(input logic [4:0] idx, input logic [15:0] d);
    wbyte(idx, 0, d[7:0]);
    wbyte(idx, 1, d[15:8]);
  endtask

  task automatic pulse_stat();
    @(negedge clk); stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  task automatic pulse_vb();
    @(negedge clk); vblank = 1; @(negedge clk); vblank = 0;
  endtask

  task automatic wait_flag(input bit tbl, input string req);
    int n = 0;
    while ((tbl ? flag_tbl : flag_blk) !== 1'b1 && n < 20000) begin
      @(negedge clk); n++;
    end
    @(negedge clk); #2;
    chk((tbl ? flag_tbl : flag_blk) === 1'b1, req, n, 0);
  endtask

  task automatic run_blk(input logic [7:0] ctrl, input logic [15:0] s, input logic [15:0] d,
                         input logic [15:0] len);
    wbyte(5'h0F, 0, ctrl);
    wword(5'h10, s);
    wword(5'h11, d);
    wbyte(5'h12, 0, len[7:0]);
    m_src = s; m_dst = d; m_sdec = ctrl[2]; m_ddec = ctrl[3]; rdn = 0; wrn = 0;
    blk_on = 1;
    wbyte(5'h12, 1, len[15:8]);
    wait_flag(0, "R5 block flag");
    chk(wrn == int'(len) + 1, "R3 word count", wrn, int'(len) + 1);
    chk(irq == ctrl[1], "R5 irq gating", irq, ctrl[1]);
    blk_on = 0;
    pulse_stat();
  endtask

  task automatic check_tbl(input logic [15:0] base, input int i);
    @(negedge clk); tbl_raddr = 8'(i);
    @(negedge clk); #2;
    chk(tbl_rdata == vread(base + 16'(i)), "R11 table entry", tbl_rdata, vread(base + 16'(i)));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk); #2;
    chk(!flag_blk && !flag_tbl && !irq && !vram_req, "R1 reset state",
        {flag_blk, flag_tbl, irq, vram_req}, 0);

    // R2: lower count byte alone does nothing
    wbyte(5'h0F, 0, 8'h02);
    wword(5'h10, 16'h0100);
    wword(5'h11, 16'h0200);
    wbyte(5'h12, 0, 8'h03);
    repeat (20) @(negedge clk);
    #2 chk(!flag_blk && rdn == 0, "R2 no start on lower byte", flag_blk, 0);

    // ascending copy with irq enabled
    run_blk(8'h02, 16'h0100, 16'h0200, 16'h0003);
    #2 chk(!flag_blk && !irq, "R10 flags cleared", {flag_blk, irq}, 0);

    // both descending, overlap and wrap, irq disabled
    run_blk(8'h0C, 16'h0001, 16'hFFFE, 16'h0004);
    // source down, destination up across wrap
    run_blk(8'h06, 16'h0500, 16'hFFFE, 16'h0003);
    // single word
    run_blk(8'h00, 16'h0700, 16'h0800, 16'h0000);

    // R6: armed one-shot fill
    wbyte(5'h0F, 0, 8'h01);
    rdn = 0;
    wword(5'h13, 16'h0300);
    repeat (30) @(negedge clk);
    #2 chk(rdn == 0 && !flag_tbl, "R6 no fill before vblank", rdn, 0);
    m_src = 16'h0300; tbl_on = 1;
    pulse_vb();
    wait_flag(1, "R8 table flag");
    chk(rdn == 256, "R6 fill length", rdn, 256);
    chk(irq == 1'b1, "R8 irq enabled", irq, 1);
    tbl_on = 0;
    check_tbl(16'h0300, 0);
    check_tbl(16'h0300, 1);
    check_tbl(16'h0300, 128);
    check_tbl(16'h0300, 255);
    pulse_stat();

    // R7: later vblank without re-arm and without repeat
    rdn = 0;
    pulse_vb();
    repeat (400) @(negedge clk);
    #2 chk(rdn == 0 && !flag_tbl, "R7 no fill unarmed", rdn, 0);

    // R7: repeat mode, wrapping source, irq off
    wbyte(5'h0F, 0, 8'h10);
    wword(5'h13, 16'hFF80);
    for (int f = 0; f < 2; f++) begin
      m_src = 16'hFF80; rdn = 0; tbl_on = 1;
      pulse_vb();
      wait_flag(1, "R7 repeat fill");
      chk(rdn == 256, "R7 repeat length", rdn, 256);
      chk(irq == 1'b0, "R8 irq gated off", irq, 0);
      tbl_on = 0;
      pulse_stat();
    end
    check_tbl(16'hFF80, 8'h90);
    check_tbl(16'hFF80, 8'h7F);

    repeat (5) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule